// File: doc/BRIEF.md
# Paged Packet Memory Allocator

This unit hands out the fixed-size slots of an on-chip packet buffer. The buffer is `MEM_BYTES` large (8 KB by default) and is cut into `SLOT_BYTES` slots (2 KB by default), so four packet numbers exist. The unit tracks which slots are in use with a bitmap, in which a 1 means the slot is free.

Software drives the unit with single-cycle commands:
- allocate a slot for transmit, with a page request;
- free a named packet number;
- release the slot at the head of the receive queue;
- push a packet number into the transmit queue;
- reset the whole allocator.

The page request is counted in 256-byte pages and encoded as the page count minus one. A driver derives it as ((frame length with bit 0 cleared) + 6) >> 8.

The transmit side keeps a queue of packet numbers. When the transmitter reports a finished frame, the head entry is retired, and with automatic release enabled its slot is returned to the pool. The receive side takes a free slot for each incoming frame and queues that packet number for software. The slot stays taken until software releases it.

Top module: `pkt_page_alloc`

## Requirements
- R1: After `rst_n` is deasserted, all slots are free, `busy`, `alloc_irq`, `alloc_fail` and `tx_empty_irq` are 0, `txq_valid` is 0 and `rx_empty` is 1.
- R2: An allocate command (`cmd_op` = 1) with a legal page request takes the lowest-numbered free slot. One cycle later it reports that slot on `alloc_pnum` with `alloc_fail` = 0.
- R3: An allocate command whose `cmd_pages` exceeds `MAX_PAGES` (7, the encoded count-minus-one) takes no slot. It reports `alloc_fail` = 1 with `alloc_pnum` = 0 and does not set `alloc_irq`.
- R4: An allocate command that finds no free slot reports `alloc_fail` = 1 with `alloc_pnum` = 0.
- R5: `alloc_irq` is set by each successful allocation and cleared by a pulse on `alloc_irq_clr`. A set in the same cycle as a clear wins.
- R6: The commands reset (2), release-receive (3) and free (4) raise `busy` on the next cycle and hold it for exactly `BUSY_CYC` cycles. Their effect becomes visible in the cycle `busy` falls. Every command presented while `busy` is 1 is ignored.
- R7: The free command returns the slot named by `cmd_pnum` to the pool.
- R8: The enqueue command (5) appends `cmd_pnum` to the transmit queue. `txq_valid` and `txq_pnum` show the queue head, and a `tx_done` pulse retires that head.
- R9: On `tx_done` with `autorel_en` = 1, the retired slot becomes free. With `autorel_en` = 0 it stays taken. `tx_empty_irq` is set when `tx_done` empties the queue, and it is cleared by a pulse on `tx_empty_clr`.
- R10: A `rx_frame_in` pulse takes the lowest free slot not granted to an allocate in the same cycle and pushes it to the receive queue. One cycle later `rx_grant_valid` is 1, with `rx_grant_ok` and `rx_grant_pnum` giving the result, or `rx_grant_ok` = 0 if no slot is free.
- R11: The release-receive command frees the slot at the head of the receive queue and removes it. `rx_empty` and `rx_head_pnum` show the queue state.
- R12: The reset command frees all slots, empties both queues, and clears `alloc_irq`, `alloc_fail`, `alloc_pnum` and `tx_empty_irq`. Receive frames are refused while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 allocate, 2 reset, 3 release-receive, 4 free, 5 enqueue |
| cmd_pages | input | PAGE_W | Page request, page count minus one |
| cmd_pnum | input | log2(NUM_SLOTS) | Packet number for free and enqueue |
| busy | output | 1 | A multi-cycle command is running |
| alloc_pnum | output | log2(NUM_SLOTS) | Packet number granted by the last allocation |
| alloc_fail | output | 1 | Last allocation failed |
| alloc_irq | output | 1 | Allocation-done status |
| alloc_irq_clr | input | 1 | Clears `alloc_irq` |
| autorel_en | input | 1 | Free slots when their transmission completes |
| txq_valid | output | 1 | Transmit queue is not empty |
| txq_pnum | output | log2(NUM_SLOTS) | Packet number at the transmit queue head |
| tx_done | input | 1 | Transmitter finished the head frame |
| tx_empty_irq | output | 1 | Transmit queue drained status |
| tx_empty_clr | input | 1 | Clears `tx_empty_irq` |
| rx_frame_in | input | 1 | Receiver needs a slot for a frame |
| rx_grant_valid | output | 1 | Receive slot request answered |
| rx_grant_ok | output | 1 | Receive slot was granted |
| rx_grant_pnum | output | log2(NUM_SLOTS) | Granted receive packet number |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head_pnum | output | log2(NUM_SLOTS) | Packet number at the receive queue head |

## Verification
Allocation results, `alloc_irq`, receive grants, queue heads and `tx_empty_irq` all come from registers. Each is due on the first cycle after the clock edge that captures its stimulus. The bench drives inputs on the falling edge and reads the outputs on the next falling edge.

The multi-cycle commands are timed from the edge that accepts them. `busy` is read one and three cycles after that edge and must be high both times. It is read again four cycles after that edge and must be low, and the freed or cleared state is checked at that point. A command issued in the middle of the busy window is checked to have no effect.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_ALLOC      = 3'd1,
      OP_RESET      = 3'd2,
      OP_RELEASE_RX = 3'd3,
      OP_FREE       = 3'd4,
      OP_ENQUEUE    = 3'd5
   } alloc_op_e;
endpackage

// File: rtl/pkt_alloc_pick.sv
// Lowest-index-first selector over a free bitmap.
module pkt_alloc_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pkt_alloc_fifo.sv
// Small packet-number queue with flush; push when full and pop when empty are dropped.
module pkt_alloc_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic [AW:0]  count,
   output logic         full
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("pkt_alloc_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full    = (count == (AW + 1)'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && (count != '0);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= push_data;
   end

   // R8: a lone pop shortens the queue by exactly one entry
   p_pop_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0 && !push && !flush) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/pkt_alloc_busy.sv
// Busy window for multi-cycle commands; fire marks the last busy cycle.
module pkt_alloc_busy #(
   parameter int CYC = 3,
   localparam int CW = $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic fire
);
   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("pkt_alloc_busy: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);
   assign fire = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (start && !busy) cnt <= CW'(CYC);
      else if (busy)          cnt <= cnt - 1'b1;
   end

   // R6: the busy window closes right after its final cycle
   p_fire_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !busy);
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
   import pkt_alloc_pkg::*;
#(
   parameter int MEM_BYTES  = 8192,
   parameter int SLOT_BYTES = 2048,
   parameter int PAGE_BYTES = 256,
   parameter int NUM_SLOTS  = MEM_BYTES / SLOT_BYTES,
   parameter int MAX_PAGES  = SLOT_BYTES / PAGE_BYTES - 1,
   parameter int PAGE_W     = 4,
   parameter int BUSY_CYC   = 3,
   parameter int RXQ_DEPTH  = NUM_SLOTS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [2:0]                   cmd_op,
   input  logic [PAGE_W-1:0]            cmd_pages,
   input  logic [$clog2(NUM_SLOTS)-1:0] cmd_pnum,
   output logic                         busy,
   output logic [$clog2(NUM_SLOTS)-1:0] alloc_pnum,
   output logic                         alloc_fail,
   output logic                         alloc_irq,
   input  logic                         alloc_irq_clr,
   input  logic                         autorel_en,
   output logic                         txq_valid,
   output logic [$clog2(NUM_SLOTS)-1:0] txq_pnum,
   input  logic                         tx_done,
   output logic                         tx_empty_irq,
   input  logic                         tx_empty_clr,
   input  logic                         rx_frame_in,
   output logic                         rx_grant_valid,
   output logic                         rx_grant_ok,
   output logic [$clog2(NUM_SLOTS)-1:0] rx_grant_pnum,
   output logic                         rx_empty,
   output logic [$clog2(NUM_SLOTS)-1:0] rx_head_pnum
);
   localparam int PN_W  = $clog2(NUM_SLOTS);
   localparam int TQ_AW = $clog2(NUM_SLOTS);
   localparam int RQ_AW = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;

   generate
      if (NUM_SLOTS < 2 || (1 << PN_W) != NUM_SLOTS) begin : g_bad_slots
         $error("pkt_page_alloc: slot count must be a power of two, at least 2");
      end
      if (MAX_PAGES >= (1 << PAGE_W)) begin : g_bad_pages
         $error("pkt_page_alloc: PAGE_W too narrow for MAX_PAGES");
      end
   endgenerate

   alloc_op_e op, pend_op;
   logic [PN_W-1:0] pend_pnum;
   assign op = alloc_op_e'(cmd_op);

   logic accept, acc_alloc, acc_long, acc_enq, fire;
   assign accept    = cmd_valid && !busy;
   assign acc_alloc = accept && (op == OP_ALLOC);
   assign acc_enq   = accept && (op == OP_ENQUEUE);
   assign acc_long  = accept && (op == OP_RESET || op == OP_RELEASE_RX || op == OP_FREE);

   pkt_alloc_busy #(.CYC(BUSY_CYC)) busy_i (
      .clk(clk), .rst_n(rst_n), .start(acc_long), .busy(busy), .fire(fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_op   <= OP_NOP;
         pend_pnum <= '0;
      end else if (acc_long) begin
         pend_op   <= op;
         pend_pnum <= cmd_pnum;
      end
   end

   logic fire_reset, fire_free, fire_rel;
   assign fire_reset = fire && (pend_op == OP_RESET);
   assign fire_free  = fire && (pend_op == OP_FREE);
   assign fire_rel   = fire && (pend_op == OP_RELEASE_RX);

   // Slot ownership, 1 = free
   logic [NUM_SLOTS-1:0] free_map, alloc_mask, rx_mask, set_mask;
   logic                 a_found, b_found, pages_ok, alloc_take, rx_accept, rx_take;
   logic [PN_W-1:0]      a_idx, b_idx;

   pkt_alloc_pick #(.N(NUM_SLOTS)) pick_tx_i (
      .vec(free_map), .found(a_found), .idx(a_idx));

   assign pages_ok   = (cmd_pages <= PAGE_W'(MAX_PAGES));
   assign alloc_take = acc_alloc && pages_ok && a_found;
   assign alloc_mask = alloc_take ? (NUM_SLOTS'(1) << a_idx) : '0;

   pkt_alloc_pick #(.N(NUM_SLOTS)) pick_rx_i (
      .vec(free_map & ~alloc_mask), .found(b_found), .idx(b_idx));

   // Transmit queue
   logic [TQ_AW:0] txq_count;
   logic           txq_full, tx_pop, tx_last;
   pkt_alloc_fifo #(.DEPTH(NUM_SLOTS), .W(PN_W)) txq_i (
      .clk(clk), .rst_n(rst_n), .flush(fire_reset), .push(acc_enq),
      .push_data(cmd_pnum), .pop(tx_done), .head(txq_pnum),
      .count(txq_count), .full(txq_full));
   assign txq_valid = (txq_count != '0);
   assign tx_last   = (txq_count == (TQ_AW + 1)'(1));
   assign tx_pop    = tx_done && txq_valid;

   // Receive queue
   logic [RQ_AW:0] rxq_count;
   logic           rxq_full;
   assign rx_accept = rx_frame_in && !(busy && pend_op == OP_RESET);
   assign rx_take   = rx_accept && b_found && !rxq_full;
   assign rx_mask   = rx_take ? (NUM_SLOTS'(1) << b_idx) : '0;
   pkt_alloc_fifo #(.DEPTH(RXQ_DEPTH), .W(PN_W)) rxq_i (
      .clk(clk), .rst_n(rst_n), .flush(fire_reset), .push(rx_take),
      .push_data(b_idx), .pop(fire_rel), .head(rx_head_pnum),
      .count(rxq_count), .full(rxq_full));
   assign rx_empty = (rxq_count == '0);

   always_comb begin
      set_mask = '0;
      if (tx_pop && autorel_en)   set_mask = set_mask | (NUM_SLOTS'(1) << txq_pnum);
      if (fire_rel && !rx_empty) set_mask = set_mask | (NUM_SLOTS'(1) << rx_head_pnum);
      if (fire_free)             set_mask = set_mask | (NUM_SLOTS'(1) << pend_pnum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          free_map <= '1;
      else if (fire_reset) free_map <= '1;
      else                 free_map <= (free_map | set_mask) & ~(alloc_mask | rx_mask);
   end

   // Allocation result and status bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_pnum   <= '0;
         alloc_fail   <= 1'b0;
         alloc_irq    <= 1'b0;
         tx_empty_irq <= 1'b0;
      end else if (fire_reset) begin
         alloc_pnum   <= '0;
         alloc_fail   <= 1'b0;
         alloc_irq    <= 1'b0;
         tx_empty_irq <= 1'b0;
      end else begin
         if (acc_alloc) begin
            alloc_fail <= !alloc_take;
            alloc_pnum <= alloc_take ? a_idx : '0;
         end
         if (alloc_take)         alloc_irq <= 1'b1;
         else if (alloc_irq_clr) alloc_irq <= 1'b0;
         if (tx_pop && tx_last && !(acc_enq && !txq_full)) tx_empty_irq <= 1'b1;
         else if (tx_empty_clr)                            tx_empty_irq <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_grant_valid <= 1'b0;
         rx_grant_ok    <= 1'b0;
         rx_grant_pnum  <= '0;
      end else begin
         rx_grant_valid <= rx_accept;
         rx_grant_ok    <= rx_take;
         rx_grant_pnum  <= rx_take ? b_idx : '0;
      end
   end

   // R6: an accepted multi-cycle command makes the unit busy
   p_long_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_long |=> busy);
   // R3: an oversized request fails without raising the allocation status
   p_oversize_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_alloc && cmd_pages > PAGE_W'(MAX_PAGES)) |=> (alloc_fail && !$rose(alloc_irq)));
   // R2: a reported grant names a slot now owned
   p_grant_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_alloc |=> (alloc_fail || !free_map[alloc_pnum]));
   // R10: a granted receive slot is owned
   p_rx_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_grant_ok |-> !free_map[rx_grant_pnum]);
   // R12: the reset command leaves every slot free and both queues empty
   p_reset_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fire_reset |=> (&free_map && !txq_valid && rx_empty));
endmodule

// File: tb/pkt_page_alloc_tb_top.sv
`timescale 1ns/1ps
module pkt_page_alloc_tb_top;
   localparam logic [2:0] C_ALLOC = 3'd1, C_RESET = 3'd2, C_RELRX = 3'd3,
                          C_FREE = 3'd4, C_ENQ = 3'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 0, alloc_irq_clr = 0, autorel_en = 0, tx_done = 0;
   logic tx_empty_clr = 0, rx_frame_in = 0;
   logic [2:0] cmd_op = 0;
   logic [3:0] cmd_pages = 0;
   logic [1:0] cmd_pnum = 0;
   logic busy, alloc_fail, alloc_irq, txq_valid, tx_empty_irq;
   logic rx_grant_valid, rx_grant_ok, rx_empty;
   logic [1:0] alloc_pnum, txq_pnum, rx_grant_pnum, rx_head_pnum;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   pkt_page_alloc dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pages(cmd_pages), .cmd_pnum(cmd_pnum), .busy(busy),
      .alloc_pnum(alloc_pnum), .alloc_fail(alloc_fail), .alloc_irq(alloc_irq),
      .alloc_irq_clr(alloc_irq_clr), .autorel_en(autorel_en),
      .txq_valid(txq_valid), .txq_pnum(txq_pnum), .tx_done(tx_done),
      .tx_empty_irq(tx_empty_irq), .tx_empty_clr(tx_empty_clr),
      .rx_frame_in(rx_frame_in), .rx_grant_valid(rx_grant_valid),
      .rx_grant_ok(rx_grant_ok), .rx_grant_pnum(rx_grant_pnum),
      .rx_empty(rx_empty), .rx_head_pnum(rx_head_pnum));

   // {pages[3:0], expected fail, expected pnum[1:0]}, walked from reset
   localparam logic [6:0] VEC [7] = '{
      {4'd0,  1'b0, 2'd0}, {4'd7,  1'b0, 2'd1}, {4'd8,  1'b1, 2'd0},
      {4'd15, 1'b1, 2'd0}, {4'd3,  1'b0, 2'd2}, {4'd1,  1'b0, 2'd3},
      {4'd0,  1'b1, 2'd0}};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [2:0] op, input logic [3:0] pg, input logic [1:0] pn);
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_pages = pg; cmd_pnum = pn;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic pulse_clr;
      @(negedge clk); alloc_irq_clr = 1;
      @(negedge clk); alloc_irq_clr = 0;
   endtask

   task automatic pulse_txdone;
      @(negedge clk); tx_done = 1;
      @(negedge clk); tx_done = 0;
   endtask

   task automatic wait_idle;
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 txq_valid", txq_valid, 0);
      chk("R1 alloc_irq", alloc_irq, 0);
      chk("R1 tx_empty_irq", tx_empty_irq, 0);

      // R2 R3 R4 R5 vector walk
      for (int i = 0; i < 7; i++) begin
         pulse_clr;
         do_cmd(C_ALLOC, VEC[i][6:3], 2'd0);
         chk("R2_R3_R4 fail", alloc_fail, VEC[i][2]);
         chk("R2_R3_R4 pnum", alloc_pnum, VEC[i][1:0]);
         chk("R5 irq follows success", alloc_irq, !VEC[i][2]);
      end

      // R6 R7 free with busy window, second command ignored
      do_cmd(C_FREE, 4'd0, 2'd1);
      chk("R6 busy first cycle", busy, 1);
      do_cmd(C_FREE, 4'd0, 2'd2);
      chk("R6 busy third cycle", busy, 1);
      @(negedge clk);
      chk("R6 busy ends", busy, 0);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R7 freed slot reused", alloc_pnum, 1);
      chk("R7 freed slot ok", alloc_fail, 0);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R6 command during busy ignored", alloc_fail, 1);

      // R8 R9 transmit queue with autorelease
      autorel_en = 1;
      do_cmd(C_ENQ, 4'd0, 2'd2);
      chk("R8 txq_valid", txq_valid, 1);
      chk("R8 txq_pnum", txq_pnum, 2);
      pulse_txdone;
      chk("R8 queue drained", txq_valid, 0);
      chk("R9 tx_empty_irq", tx_empty_irq, 1);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R9 autorelease freed", alloc_pnum, 2);
      chk("R9 autorelease ok", alloc_fail, 0);
      @(negedge clk); tx_empty_clr = 1;
      @(negedge clk); tx_empty_clr = 0;
      chk("R9 tx_empty_clr", tx_empty_irq, 0);
      autorel_en = 0;
      do_cmd(C_ENQ, 4'd0, 2'd3);
      pulse_txdone;
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R9 no autorelease keeps slot", alloc_fail, 1);

      // R12 reset command
      chk("R12 irq set before", alloc_irq, 1);
      do_cmd(C_RESET, 4'd0, 2'd0);
      wait_idle;
      chk("R12 alloc_irq cleared", alloc_irq, 0);
      chk("R12 alloc_fail cleared", alloc_fail, 0);
      chk("R12 tx_empty_irq cleared", tx_empty_irq, 0);
      chk("R12 rx_empty", rx_empty, 1);
      chk("R12 txq empty", txq_valid, 0);

      // R10 same-cycle allocate and receive request
      @(negedge clk);
      cmd_valid = 1; cmd_op = C_ALLOC; cmd_pages = 0; rx_frame_in = 1;
      @(negedge clk);
      cmd_valid = 0; rx_frame_in = 0;
      chk("R12 all free after reset", alloc_pnum, 0);
      chk("R10 grant valid", rx_grant_valid, 1);
      chk("R10 grant ok", rx_grant_ok, 1);
      chk("R10 grant skips alloc slot", rx_grant_pnum, 1);
      chk("R10 rx not empty", rx_empty, 0);
      chk("R10 rx head", rx_head_pnum, 1);
      @(negedge clk); rx_frame_in = 1;
      @(negedge clk); rx_frame_in = 0;
      chk("R10 second grant", rx_grant_pnum, 2);
      chk("R10 head unchanged", rx_head_pnum, 1);

      // R11 release receive head
      do_cmd(C_RELRX, 4'd0, 2'd0);
      wait_idle;
      chk("R11 head advanced", rx_head_pnum, 2);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R11 released slot reused", alloc_pnum, 1);
      do_cmd(C_RELRX, 4'd0, 2'd0);
      wait_idle;
      chk("R11 rx empty", rx_empty, 1);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R11 second release freed", alloc_pnum, 2);
      do_cmd(C_ALLOC, 4'd0, 2'd0);
      chk("R2 last slot", alloc_pnum, 3);
      @(negedge clk); rx_frame_in = 1;
      @(negedge clk); rx_frame_in = 0;
      chk("R10 refused valid", rx_grant_valid, 1);
      chk("R10 refused when full", rx_grant_ok, 0);
      chk("R10 nothing queued", rx_empty, 1);

      // R5 clear
      pulse_clr;
      chk("R5 irq cleared", alloc_irq, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule